// File: doc/BRIEF.md
# Cipher FIFO DMA Feed Channel

This block is a single DMA channel that shuttles 32-bit words between system memory and the word-wide stream port of a 128-bit block-cipher engine. One parameter selects the direction. In the receive flavour, the channel reads memory and hands the words to the engine. In the transmit flavour, it accepts words from the engine and writes them to memory. A small word FIFO decouples the two sides. Two copies of the block, one of each flavour, make up a complete feed path.

Software programs a segment in two steps. It first writes the start address and then writes the byte length, and the length write itself launches the transfer. When the last word of the segment has crossed the memory port, the channel pulses `done` toward the interrupt logic. Software then loads the next segment the same way. A control write can turn on byte reversal inside each word, or flush the FIFO and abort the running segment. The FIFO full and empty flags are brought out so that a status register elsewhere can report them.

Top module: `feed_channel`

## Requirements
- R1: After reset, `mem_req`, `done`, `fifo_full`, `st_out_valid` and `st_in_ready` are 0 and `fifo_empty` is 1.
- R2: `reg_sel` value 1 is the length register. A length write while idle starts the segment at once. In the cycle after the write, `mem_req` is 1 (receive) and `mem_addr` equals the latched address. Each later word uses the previous address plus 4.
- R3: A segment of L bytes moves exactly L/4 words across the memory port, and then the channel issues no further requests.
- R4: `done` is high for exactly one cycle, in the cycle after the acknowledge of the segment's last word.
- R5: A length write is ignored when its low LEN_W bits are zero, when they are not a multiple of 16, or when a segment is already running.
- R6: `reg_sel` value 0 is the address register. Writing it during a segment leaves that segment's addresses unchanged. The new value applies from the next accepted length write.
- R7: `reg_sel` value 2 is the control register, where bit 1 enables byte reversal. When it is set, memory-side data has byte 0 exchanged with byte 3 and byte 1 exchanged with byte 2. This applies to read data on receive and write data on transmit. When it is clear, data passes unchanged.
- R8: Control bit 0 is a one-shot flush. A write with it set empties the FIFO and ends the running segment without a `done`. The bit is not retained, so later control writes with bit 0 clear flush nothing.
- R9: `fifo_full` and `fifo_empty` follow the FIFO occupancy. The receive channel raises no `mem_req` while the FIFO is full, and the transmit channel holds `st_in_ready` low while it is full.
- R10: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen, unless a flush intervenes.
- R11: Words leave the stream port (receive) or reach memory (transmit) in the order they entered the channel.
- R12: A register write with `reg_sel` value 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 length, 2 control |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 for a memory write (transmit), 0 for a read |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_wdata | output | 32 | Write data (transmit) |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` (receive) |
| st_out_valid | output | 1 | Word available to the engine (receive) |
| st_out_data | output | 32 | Word to the engine |
| st_out_ready | input | 1 | Engine takes the word |
| st_in_valid | input | 1 | Engine offers a word (transmit) |
| st_in_data | input | 32 | Word from the engine |
| st_in_ready | output | 1 | Channel takes the word |
| done | output | 1 | One-cycle segment completion pulse |
| fifo_full | output | 1 | FIFO full flag |
| fifo_empty | output | 1 | FIFO empty flag |

## Verification
Receive segments are run under four conditions: a memory that acknowledges every cycle with an engine that is always ready, a memory that acknowledges every other cycle, an engine that accepts only every third cycle, and an engine that never accepts. The last case separates FIFO back-pressure from plain request throttling. Transmit segments are fed in bursts and checked with byte reversal both on and off, so a swap applied on the wrong side of the FIFO shows up. Malformed lengths, length writes during a running segment, address writes in the middle of a segment and flushes at partial occupancy are each followed by a valid segment. This separates a rejected command from corrupted channel state.

// File: rtl/feed_pkg.sv
package feed_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } feed_sel_e;

  localparam int CTRL_FLUSH_BIT = 0;
  localparam int CTRL_SWAP_BIT  = 1;

  // reverse byte order of a 32-bit word when en is set
  function automatic logic [31:0] swap_bytes(input logic [31:0] w, input logic en);
    return en ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

endpackage

// File: rtl/feed_fifo.sv
module feed_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + AW'(1);
      if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + AW'(1);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem_q[wr_q] <= wdata;
  end

  assign rdata = mem_q[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/feed_regs.sv
module feed_regs
  import feed_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int WORD_W = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata,
  input  logic              busy,
  output logic [31:0]       addr_q,
  output logic              swap_q,
  output logic              start,
  output logic [WORD_W-1:0] start_words,
  output logic              flush
);
  logic [31:0]      addr_d;
  logic             swap_d;
  logic [LEN_W-1:0] len_field;
  logic             len_ok;
  logic [31:0]      unused_hi;

  assign len_field   = wdata[LEN_W-1:0];
  assign len_ok      = (len_field != '0) && (len_field[3:0] == 4'd0);
  assign start       = we && (feed_sel_e'(sel) == SEL_LEN) && !busy && len_ok;
  assign start_words = len_field[LEN_W-1:2];
  assign flush       = we && (feed_sel_e'(sel) == SEL_CTRL) && wdata[CTRL_FLUSH_BIT];
  assign unused_hi   = wdata;

  always_comb begin
    addr_d = addr_q;
    swap_d = swap_q;
    if (we && feed_sel_e'(sel) == SEL_ADDR) addr_d = wdata;
    if (we && feed_sel_e'(sel) == SEL_CTRL) swap_d = wdata[CTRL_SWAP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      swap_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      swap_q <= swap_d;
    end
  end

endmodule

// File: rtl/feed_mover.sv
module feed_mover
  import feed_pkg::*;
#(
  parameter bit IS_TX  = 1'b0,
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_addr,
  input  logic [WORD_W-1:0] start_words,
  input  logic              flush,
  input  logic              swap,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic [31:0]       fifo_rdata,
  output logic              fifo_push,
  output logic [31:0]       fifo_wdata,
  output logic              fifo_pop,
  output logic              st_out_valid,
  output logic [31:0]       st_out_data,
  input  logic              st_out_ready,
  input  logic              st_in_valid,
  input  logic [31:0]       st_in_data,
  output logic              st_in_ready,
  output logic              done,
  output logic              busy
);
  logic [31:0]       ptr_q, ptr_d;
  logic [WORD_W-1:0] mem_left_q, mem_left_d;
  logic [WORD_W-1:0] in_left_q, in_left_d;
  logic              done_q, done_d;
  logic              mem_hs;
  logic              unused_dir;

  assign busy     = (mem_left_q != '0);
  assign mem_addr = ptr_q;
  assign mem_hs   = mem_req && mem_ack;
  assign done     = done_q;

  generate
    if (IS_TX) begin : g_tx
      assign st_in_ready  = (in_left_q != '0) && !fifo_full;
      assign fifo_push    = st_in_valid && st_in_ready;
      assign fifo_wdata   = st_in_data;
      assign mem_req      = (mem_left_q != '0) && !fifo_empty;
      assign mem_we       = 1'b1;
      assign mem_wdata    = swap_bytes(fifo_rdata, swap);
      assign fifo_pop     = mem_hs;
      assign st_out_valid = 1'b0;
      assign st_out_data  = '0;
      assign unused_dir   = ^{mem_rdata, st_out_ready};
    end else begin : g_rx
      assign mem_req      = (in_left_q != '0) && !fifo_full;
      assign mem_we       = 1'b0;
      assign mem_wdata    = '0;
      assign fifo_push    = mem_hs;
      assign fifo_wdata   = swap_bytes(mem_rdata, swap);
      assign st_out_valid = !fifo_empty;
      assign st_out_data  = fifo_rdata;
      assign fifo_pop     = st_out_valid && st_out_ready;
      assign st_in_ready  = 1'b0;
      assign unused_dir   = ^{st_in_valid, st_in_data};
    end
  endgenerate

  always_comb begin
    ptr_d      = ptr_q;
    mem_left_d = mem_left_q;
    in_left_d  = in_left_q;
    done_d     = 1'b0;
    if (flush) begin
      mem_left_d = '0;
      in_left_d  = '0;
    end else if (start) begin
      ptr_d      = start_addr;
      mem_left_d = start_words;
      in_left_d  = start_words;
    end else begin
      if (mem_hs) begin
        ptr_d      = ptr_q + 32'd4;
        mem_left_d = mem_left_q - WORD_W'(1);
        done_d     = (mem_left_q == WORD_W'(1));
      end
      if (fifo_push) in_left_d = in_left_q - WORD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      mem_left_q <= '0;
      in_left_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      ptr_q      <= ptr_d;
      mem_left_q <= mem_left_d;
      in_left_q  <= in_left_d;
      done_q     <= done_d;
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_segment_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_idle_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !flush) |=> mem_req);
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !flush) |=> $stable(mem_addr));

endmodule

// File: rtl/feed_channel.sv
module feed_channel
  import feed_pkg::*;
#(
  parameter bit IS_TX      = 1'b0,
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        st_out_valid,
  output logic [31:0] st_out_data,
  input  logic        st_out_ready,
  input  logic        st_in_valid,
  input  logic [31:0] st_in_data,
  output logic        st_in_ready,
  output logic        done,
  output logic        fifo_full,
  output logic        fifo_empty
);
  localparam int WORD_W = LEN_W - 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_s_n;
  logic [31:0]       addr_q;
  logic              swap_q, start, flush, busy;
  logic [WORD_W-1:0] start_words;
  logic              f_push, f_pop;
  logic [31:0]       f_wdata, f_rdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  feed_regs #(.LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .addr_q(addr_q), .swap_q(swap_q), .start(start),
    .start_words(start_words), .flush(flush)
  );

  feed_mover #(.IS_TX(IS_TX), .WORD_W(WORD_W)) u_mover (
    .clk(clk), .rst_n(rst_s_n), .start(start), .start_addr(addr_q),
    .start_words(start_words), .flush(flush), .swap(swap_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_rdata(f_rdata),
    .fifo_push(f_push), .fifo_wdata(f_wdata), .fifo_pop(f_pop),
    .st_out_valid(st_out_valid), .st_out_data(st_out_data), .st_out_ready(st_out_ready),
    .st_in_valid(st_in_valid), .st_in_data(st_in_data), .st_in_ready(st_in_ready),
    .done(done), .busy(busy)
  );

  feed_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s_n), .clr(flush), .push(f_push), .wdata(f_wdata),
    .pop(f_pop), .rdata(f_rdata), .full(fifo_full), .empty(fifo_empty)
  );

  // a malformed length written while idle must leave the channel idle
  assert_bad_len_ignored_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_we && feed_sel_e'(reg_sel) == SEL_LEN && !busy &&
     (reg_wdata[LEN_W-1:0] == '0 || reg_wdata[3:0] != 4'd0)) |=> !busy);
  assert_flush_no_done_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    flush |=> (!done && fifo_empty && !mem_req));

endmodule

// File: tb/test_feed_channel.sv
module feed_ref #(
  parameter bit IS_TX = 1'b0,
  parameter int DEPTH = 4,
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        st_out_ready,
  input  logic        st_in_valid,
  input  logic [31:0] st_in_data,
  output logic        e_mem_req,
  output logic [31:0] e_mem_addr,
  output logic [31:0] e_mem_wdata,
  output logic        e_st_out_valid,
  output logic [31:0] e_st_out_data,
  output logic        e_st_in_ready,
  output logic        e_done,
  output logic        e_full,
  output logic        e_empty
);
  int          left_mem, left_in;
  logic [31:0] base, ptr;
  logic        swp, was_busy, hs_mem, hs_in, hs_out;
  logic [LEN_W-1:0] len;
  logic [31:0] q[$];

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_mem = 0; left_in = 0; base = 0; ptr = 0; swp = 0; e_done = 0;
      q.delete();
    end else begin
      hs_mem   = e_mem_req && mem_ack;
      hs_in    = e_st_in_ready && st_in_valid;
      hs_out   = e_st_out_valid && st_out_ready;
      was_busy = (left_mem > 0);
      e_done   = 0;
      if (reg_we && reg_sel == 2'd2 && reg_wdata[0]) begin
        q.delete(); left_mem = 0; left_in = 0;
      end else begin
        if (!IS_TX) begin
          if (hs_out) void'(q.pop_front());
          if (hs_mem) begin
            q.push_back(swp ? rev(mem_rdata) : mem_rdata);
            ptr += 4; left_mem--; left_in--;
            if (left_mem == 0) e_done = 1;
          end
        end else begin
          if (hs_mem) begin
            void'(q.pop_front());
            ptr += 4; left_mem--;
            if (left_mem == 0) e_done = 1;
          end
          if (hs_in) begin
            q.push_back(st_in_data); left_in--;
          end
        end
        if (reg_we && reg_sel == 2'd1) begin
          len = reg_wdata[LEN_W-1:0];
          if (!was_busy && len != 0 && len[3:0] == 0) begin
            left_mem = int'(len >> 2); left_in = left_mem; ptr = base;
          end
        end
      end
      if (reg_we && reg_sel == 2'd0) base = reg_wdata;
      if (reg_we && reg_sel == 2'd2) swp = reg_wdata[1];
    end
    e_full     = (q.size() == DEPTH);
    e_empty    = (q.size() == 0);
    e_mem_addr = ptr;
    if (!IS_TX) begin
      e_mem_req      = (left_in > 0) && (q.size() < DEPTH);
      e_st_out_valid = (q.size() > 0);
      e_st_out_data  = (q.size() > 0) ? q[0] : 32'h0;
      e_st_in_ready  = 0;
      e_mem_wdata    = 0;
    end else begin
      e_st_in_ready  = (left_in > 0) && (q.size() < DEPTH);
      e_mem_req      = (left_mem > 0) && (q.size() > 0);
      e_mem_wdata    = (q.size() > 0) ? (swp ? rev(q[0]) : q[0]) : 32'h0;
      e_st_out_valid = 0;
      e_st_out_data  = 0;
    end
  end
endmodule

module test_feed_channel;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // receive channel signals
  logic r_we, r_req, r_mwe, r_ack, r_ov, r_ordy, r_iv, r_irdy, r_done, r_full, r_empty;
  logic [1:0] r_sel;
  logic [31:0] r_wd, r_addr, r_mwd, r_rdata, r_od, r_id;
  // transmit channel signals
  logic t_we, t_req, t_mwe, t_ack, t_ov, t_ordy, t_iv, t_irdy, t_done, t_full, t_empty;
  logic [1:0] t_sel;
  logic [31:0] t_wd, t_addr, t_mwd, t_rdata, t_od, t_id;
  // reference outputs
  logic er_req, er_ov, er_irdy, er_done, er_full, er_empty;
  logic [31:0] er_addr, er_mwd, er_od;
  logic et_req, et_ov, et_irdy, et_done, et_full, et_empty;
  logic [31:0] et_addr, et_mwd, et_od;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int r_dones = 0, t_dones = 0;
  int rdy_mode = 0;
  logic r_slow = 0, t_slow = 0;
  logic [31:0] rx_got[$];
  logic [31:0] tx_src[$];
  logic [31:0] tx_mem [64];

  function automatic logic [31:0] rxw(input logic [31:0] a);
    return (a * 32'h0101_0001) ^ 32'h3C5A_0F00;
  endfunction
  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  assign r_rdata = rxw(r_addr);
  assign t_rdata = 32'h0;
  assign r_iv = 1'b0;
  assign r_id = 32'h0;
  assign t_ordy = 1'b0;

  feed_channel #(.IS_TX(1'b0), .FIFO_DEPTH(DEPTH), .LEN_W(16)) i_feed_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(r_we), .reg_sel(r_sel), .reg_wdata(r_wd),
    .mem_req(r_req), .mem_we(r_mwe), .mem_addr(r_addr), .mem_wdata(r_mwd),
    .mem_ack(r_ack), .mem_rdata(r_rdata), .st_out_valid(r_ov), .st_out_data(r_od),
    .st_out_ready(r_ordy), .st_in_valid(r_iv), .st_in_data(r_id), .st_in_ready(r_irdy),
    .done(r_done), .fifo_full(r_full), .fifo_empty(r_empty));

  feed_channel #(.IS_TX(1'b1), .FIFO_DEPTH(DEPTH), .LEN_W(16)) i_feed_channel_tx (
    .clk(clk), .rst_n(rst_n), .reg_we(t_we), .reg_sel(t_sel), .reg_wdata(t_wd),
    .mem_req(t_req), .mem_we(t_mwe), .mem_addr(t_addr), .mem_wdata(t_mwd),
    .mem_ack(t_ack), .mem_rdata(t_rdata), .st_out_valid(t_ov), .st_out_data(t_od),
    .st_out_ready(t_ordy), .st_in_valid(t_iv), .st_in_data(t_id), .st_in_ready(t_irdy),
    .done(t_done), .fifo_full(t_full), .fifo_empty(t_empty));

  feed_ref #(.IS_TX(1'b0), .DEPTH(DEPTH), .LEN_W(16)) u_ref_rx (
    .clk(clk), .rst_n(rst_n), .reg_we(r_we), .reg_sel(r_sel), .reg_wdata(r_wd),
    .mem_ack(r_ack), .mem_rdata(r_rdata), .st_out_ready(r_ordy),
    .st_in_valid(r_iv), .st_in_data(r_id),
    .e_mem_req(er_req), .e_mem_addr(er_addr), .e_mem_wdata(er_mwd),
    .e_st_out_valid(er_ov), .e_st_out_data(er_od), .e_st_in_ready(er_irdy),
    .e_done(er_done), .e_full(er_full), .e_empty(er_empty));

  feed_ref #(.IS_TX(1'b1), .DEPTH(DEPTH), .LEN_W(16)) u_ref_tx (
    .clk(clk), .rst_n(rst_n), .reg_we(t_we), .reg_sel(t_sel), .reg_wdata(t_wd),
    .mem_ack(t_ack), .mem_rdata(t_rdata), .st_out_ready(t_ordy),
    .st_in_valid(t_iv), .st_in_data(t_id),
    .e_mem_req(et_req), .e_mem_addr(et_addr), .e_mem_wdata(et_mwd),
    .e_st_out_valid(et_ov), .e_st_out_data(et_od), .e_st_in_ready(et_irdy),
    .e_done(et_done), .e_full(et_full), .e_empty(et_empty));

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // per-cycle comparison against the reference, then stimulus for the next edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 3) begin
      chk("R10", "rx mem_req", r_req, er_req);
      if (er_req) chk("R2", "rx mem_addr", r_addr, er_addr);
      chk("R11", "rx st_out_valid", r_ov, er_ov);
      if (er_ov) chk("R7", "rx st_out_data", r_od, er_od);
      chk("R4", "rx done", r_done, er_done);
      chk("R9", "rx fifo_full", r_full, er_full);
      chk("R9", "rx fifo_empty", r_empty, er_empty);
      chk("R10", "tx mem_req", t_req, et_req);
      if (et_req) begin
        chk("R2", "tx mem_addr", t_addr, et_addr);
        chk("R7", "tx mem_wdata", t_mwd, et_mwd);
        chk("R2", "tx mem_we", t_mwe, 1'b1);
      end
      chk("R9", "tx st_in_ready", t_irdy, et_irdy);
      chk("R4", "tx done", t_done, et_done);
      chk("R9", "tx fifo_full", t_full, et_full);
      chk("R9", "tx fifo_empty", t_empty, et_empty);
    end
    r_ack  = r_slow ? cyc[0] : 1'b1;
    t_ack  = t_slow ? cyc[0] : 1'b1;
    r_ordy = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 == 0) : 1'b0;
    if (r_ov && r_ordy) rx_got.push_back(r_od);
    if (t_req && t_ack) tx_mem[t_addr[7:2]] = t_mwd;
    t_iv = (tx_src.size() > 0);
    t_id = t_iv ? tx_src[0] : 32'h0;
    if (t_iv && t_irdy) void'(tx_src.pop_front());
    if (r_done) r_dones++;
    if (t_done) t_dones++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic wr(input bit tx, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    if (tx) begin t_we = 1'b1; t_sel = sel; t_wd = d; end
    else    begin r_we = 1'b1; r_sel = sel; r_wd = d; end
    @(negedge clk);
    t_we = 1'b0; r_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int exp_r, exp_t;

  initial begin
    rst_n = 1'b0; r_we = 0; t_we = 0; r_sel = 0; t_sel = 0; r_wd = 0; t_wd = 0;
    r_ack = 0; t_ack = 0; r_ordy = 0; t_iv = 0; t_id = 0;
    exp_r = 0; exp_t = 0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1", "rx mem_req", r_req, 1'b0);
    chk("R1", "rx done", r_done, 1'b0);
    chk("R1", "rx fifo_empty", r_empty, 1'b1);
    chk("R1", "rx fifo_full", r_full, 1'b0);
    chk("R1", "rx st_out_valid", r_ov, 1'b0);
    chk("R1", "tx st_in_ready", t_irdy, 1'b0);

    // R2 R3 R11: plain receive segment
    rx_got.delete();
    wr(0, 2'd0, 32'h100);
    wr(0, 2'd1, 32'd32);
    chk("R2", "rx request right after length write", r_req, 1'b1);
    chk("R2", "rx first address", r_addr, 32'h100);
    idle(40);
    exp_r++;
    chk("R3", "rx words received", rx_got.size(), 8);
    for (int i = 0; i < 8 && i < rx_got.size(); i++)
      chk("R11", "rx word order", rx_got[i], rxw(32'h100 + 4 * i));
    chk("R4", "rx done count", r_dones, exp_r);

    // R7 R9: swap, slow memory, stalled then slow engine
    rx_got.delete();
    r_slow = 1; rdy_mode = 2;
    wr(0, 2'd2, 32'h2);
    wr(0, 2'd0, 32'h200);
    wr(0, 2'd1, 32'd64);
    idle(20);
    chk("R9", "rx full with stalled engine", r_full, 1'b1);
    chk("R9", "rx no request while full", r_req, 1'b0);
    rdy_mode = 1;
    idle(120);
    exp_r++;
    chk("R3", "rx words received (swap)", rx_got.size(), 16);
    for (int i = 0; i < 16 && i < rx_got.size(); i++)
      chk("R7", "rx swapped word", rx_got[i], bsw(rxw(32'h200 + 4 * i)));
    chk("R4", "rx done count", r_dones, exp_r);

    // R5 R12: rejected length writes
    rx_got.delete();
    wr(0, 2'd2, 32'h0);
    wr(0, 2'd0, 32'h300);
    wr(0, 2'd1, 32'd0);
    idle(3);
    chk("R5", "zero length ignored", r_req, 1'b0);
    wr(0, 2'd1, 32'd24);
    idle(3);
    chk("R5", "unaligned length ignored", r_req, 1'b0);
    wr(0, 2'd3, 32'd16);
    idle(3);
    chk("R12", "select 3 write ignored", r_req, 1'b0);
    wr(0, 2'd1, 32'd16);
    wr(0, 2'd1, 32'd48);
    idle(40);
    exp_r++;
    chk("R5", "length write while busy ignored", rx_got.size(), 4);
    chk("R4", "rx done count", r_dones, exp_r);

    // R6: address write during a segment
    rx_got.delete();
    wr(0, 2'd0, 32'h400);
    wr(0, 2'd1, 32'd64);
    idle(4);
    wr(0, 2'd0, 32'h800);
    idle(120);
    chk("R6", "segment count", rx_got.size(), 16);
    for (int i = 0; i < 16 && i < rx_got.size(); i++)
      chk("R6", "old address kept", rx_got[i], rxw(32'h400 + 4 * i));
    rx_got.delete();
    wr(0, 2'd1, 32'd16);
    chk("R6", "new address used", r_addr, 32'h800);
    idle(40);
    exp_r += 2;
    chk("R6", "next segment count", rx_got.size(), 4);
    chk("R4", "rx done count", r_dones, exp_r);

    // R8: flush mid-segment, then check bit is one-shot
    rdy_mode = 2;
    wr(0, 2'd0, 32'h500);
    wr(0, 2'd1, 32'd64);
    idle(8);
    wr(0, 2'd2, 32'h1);
    chk("R8", "fifo empty after flush", r_empty, 1'b1);
    chk("R8", "no request after flush", r_req, 1'b0);
    idle(20);
    chk("R8", "no done after flush", r_dones, exp_r);
    wr(0, 2'd2, 32'h0);
    wr(0, 2'd1, 32'd16);
    idle(20);
    chk("R8", "flush bit not retained", r_full, 1'b1);
    rx_got.delete();
    rdy_mode = 0;
    idle(10);
    exp_r++;
    chk("R8", "words after flush", rx_got.size(), 4);
    chk("R4", "rx done count", r_dones, exp_r);

    // transmit: R11 plain, R7 swapped, R8 flush
    for (int i = 0; i < 8; i++) tx_src.push_back(32'h1122_3300 + i);
    wr(1, 2'd0, 32'h40);
    wr(1, 2'd1, 32'd32);
    idle(40);
    exp_t++;
    for (int i = 0; i < 8; i++)
      chk("R11", "tx memory word", tx_mem[16 + i], 32'h1122_3300 + i);
    chk("R4", "tx done count", t_dones, exp_t);

    t_slow = 1;
    wr(1, 2'd2, 32'h2);
    for (int i = 0; i < 4; i++) tx_src.push_back(32'hA1B2_C300 + i);
    wr(1, 2'd0, 32'h80);
    wr(1, 2'd1, 32'd16);
    idle(40);
    exp_t++;
    for (int i = 0; i < 4; i++)
      chk("R7", "tx swapped memory word", tx_mem[32 + i], bsw(32'hA1B2_C300 + i));
    chk("R4", "tx done count", t_dones, exp_t);

    wr(1, 2'd0, 32'hC0);
    wr(1, 2'd1, 32'd64);
    for (int i = 0; i < 3; i++) tx_src.push_back(32'h5500_0000 + i);
    idle(10);
    wr(1, 2'd2, 32'h1);
    chk("R8", "tx empty after flush", t_empty, 1'b1);
    chk("R8", "tx input closed after flush", t_irdy, 1'b0);
    idle(10);
    chk("R8", "tx no done after flush", t_dones, exp_t);

    finish_run();
  end
endmodule